// File: doc/BRIEF.md
# Decode-Stage Modifier Window Shifter

This block lives in the decode stage. A modifier instruction carries a wide immediate that describes how the instructions after it should behave. The block loads that immediate into a shift register. It then gives each following ordinary instruction one fixed-size field from the immediate, taking the lowest-order field first and shifting it out as that instruction is accepted.

There are two kinds of window. A carry window covers the next eight instructions. Each of them receives a two-bit tag saying whether it consumes a carry and whether it produces one. A level window covers the next eleven instructions. Each of them receives a three-bit interrupt mask level. When the window closes, the mask level falls back to the base level held in the block, with no instruction needed to put it back. A new modifier replaces whatever window is still open. A flush closes the window at once. The mode and the remaining count are visible on the ports, so an interrupt handler can save the window state and resume it later.

Top module: `dec_modifier_window`

## Requirements
- R1: After reset, `win_mode` is 0 (idle), `win_remain` is 0, `tag_cin` and `tag_cout` are 0, and `irq_level` is 0.
- R2: An accepted carry modifier (`inst_valid` and `is_carry_mod`) opens a carry window. `win_mode` becomes 1 and `win_remain` becomes 8. Only `mod_imm[15:0]` is used. The k-th following instruction (k = 0..7) gets field `mod_imm[2k+1:2k]`: bit 0 of the field drives `tag_cin` and bit 1 drives `tag_cout`.
- R3: The window advances by one field, and `win_remain` drops by one, only on a cycle where `inst_valid` is high and neither modifier flag is set. Cycles with `inst_valid` low leave the tags, the level, the mode and the count unchanged.
- R4: Once the eighth instruction of a carry window has been accepted, `win_mode` returns to 0 and both tags read 0.
- R5: An accepted level modifier (`inst_valid` and `is_level_mod`) opens a level window. `win_mode` becomes 2 and `win_remain` becomes 11. The k-th following instruction (k = 0..10) sees `irq_level = mod_imm[3k+2:3k]`. A value of 7 masks every interrupt except the non-maskable one.
- R6: When no level window is open, `irq_level` equals the base level. After a level window ends, the level reverts to that base level with no further input.
- R7: `lvl_we` loads `lvl_wdata` into the base level at the clock edge, unless a level window is open. In that case the write is ignored, and the base level seen after the window is the one from before it.
- R8: A modifier accepted while a window is open replaces the rest of that window. The count and the fields reload from the new immediate, and the base level restored at the end is still the one saved before the first window.
- R9: `flush` closes any window at the next edge (`win_mode` 0, `win_remain` 0), so `irq_level` shows the base level again. A modifier presented in the same cycle as `flush` is discarded.
- R10: If both modifier flags are set on an accepted instruction, it is treated as a carry modifier.
- R11: `win_remain` always equals the number of instructions left in the open window, and 0 when `win_mode` is 0 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | A decoded instruction is accepted this cycle |
| is_carry_mod | input | 1 | Accepted instruction is a carry modifier |
| is_level_mod | input | 1 | Accepted instruction is an interrupt-level modifier |
| mod_imm | input | 33 | Modifier immediate, lowest field first |
| flush | input | 1 | Close any open window |
| lvl_we | input | 1 | Write the base interrupt level |
| lvl_wdata | input | 3 | Base level value to write |
| tag_cin | output | 1 | Current instruction consumes a carry |
| tag_cout | output | 1 | Current instruction produces a carry |
| irq_level | output | 3 | Interrupt mask level currently in force |
| win_mode | output | 2 | 0 idle, 1 carry window, 2 level window |
| win_remain | output | 4 | Instructions left in the open window |

## Verification
The bench sends instructions separated by gaps of idle cycles. A design that shifted on every clock, rather than only on accepted instructions, would hand later fields to the wrong instruction. It also targets four corner cases:
- Window end. A design with an off-by-one count would leave a ninth instruction tagged or release the level one instruction early.
- Base-level write during a level window. A design that accepted it would restore the wrong level.
- A level modifier inside an open level window. A design that re-saved the applied field as the base would restore that field instead.
- A flush issued together with a modifier, and a modifier with both flags set. These cases expose wrong priority.

// File: rtl/dec_modifier_window.sv
module dec_modifier_window #(
  parameter int CARRY_N = 8,
  parameter int CARRY_W = 2,
  parameter int LVL_N   = 11,
  parameter int LVL_W   = 3,
  parameter int IMM_W   = (CARRY_N * CARRY_W > LVL_N * LVL_W) ? CARRY_N * CARRY_W : LVL_N * LVL_W,
  parameter int CNT_W   = $clog2(((CARRY_N > LVL_N) ? CARRY_N : LVL_N) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_valid,
  input  logic             is_carry_mod,
  input  logic             is_level_mod,
  input  logic [IMM_W-1:0] mod_imm,
  input  logic             flush,
  input  logic             lvl_we,
  input  logic [LVL_W-1:0] lvl_wdata,
  output logic             tag_cin,
  output logic             tag_cout,
  output logic [LVL_W-1:0] irq_level,
  output logic [1:0]       win_mode,
  output logic [CNT_W-1:0] win_remain
);
  localparam int CIMM = CARRY_N * CARRY_W;
  localparam int LIMM = LVL_N * LVL_W;

  typedef enum logic [1:0] {M_IDLE = 2'd0, M_CARRY = 2'd1, M_LVL = 2'd2} mode_t;

  mode_t            mode_q;
  logic [IMM_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] base_q;

  wire is_mod = is_carry_mod | is_level_mod;
  wire take   = inst_valid & is_mod;
  wire adv    = inst_valid & ~is_mod & (mode_q != M_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      if (lvl_we && mode_q != M_LVL) base_q <= lvl_wdata;
      if (flush) begin
        mode_q <= M_IDLE;
        sh_q   <= '0;
        cnt_q  <= '0;
      end else if (take && is_carry_mod) begin
        mode_q <= M_CARRY;
        sh_q   <= IMM_W'(mod_imm[CIMM-1:0]);
        cnt_q  <= CNT_W'(CARRY_N);
      end else if (take) begin
        mode_q <= M_LVL;
        sh_q   <= IMM_W'(mod_imm[LIMM-1:0]);
        cnt_q  <= CNT_W'(LVL_N);
      end else if (adv) begin
        sh_q  <= (mode_q == M_CARRY) ? (sh_q >> CARRY_W) : (sh_q >> LVL_W);
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) mode_q <= M_IDLE;
      end
    end
  end

  assign tag_cin    = (mode_q == M_CARRY) & sh_q[0];
  assign tag_cout   = (mode_q == M_CARRY) & sh_q[1];
  assign irq_level  = (mode_q == M_LVL) ? sh_q[LVL_W-1:0] : base_q;
  assign win_mode   = mode_q;
  assign win_remain = cnt_q;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> win_mode == 2'd0 && win_remain == '0 && irq_level == '0) // R1
    else $error("reset state wrong");
  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && is_carry_mod && !flush |=> win_mode == 2'd1 && win_remain == CNT_W'(CARRY_N)) // R2
    else $error("carry load wrong");
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !flush |=> win_remain == $past(win_remain) - CNT_W'(1)) // R3
    else $error("advance wrong");
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid && !flush |=> $stable(win_remain) && $stable(win_mode)) // R3
    else $error("hold wrong");
  AST_NO_TAG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    win_mode != 2'd1 |-> !tag_cin && !tag_cout) // R4
    else $error("tag outside carry window");
  AST_LVL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid && is_level_mod && !is_carry_mod && !flush |=> win_mode == 2'd2 && win_remain == CNT_W'(LVL_N)) // R5
    else $error("level load wrong");
  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    win_mode == 2'd2 |=> $stable(base_q)) // R7
    else $error("base changed in level window");
  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> win_mode == 2'd0 && win_remain == '0) // R9
    else $error("flush did not close window");
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode == 2'd0) == (win_remain == '0)) // R11
    else $error("count and mode disagree");
endmodule

// File: tb/dec_modifier_window_tb.sv
module dec_modifier_window_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inst_valid = 1'b0, is_carry_mod = 1'b0, is_level_mod = 1'b0, flush = 1'b0, lvl_we = 1'b0;
  logic [32:0] mod_imm = '0;
  logic [2:0] lvl_wdata = '0;
  logic tag_cin, tag_cout;
  logic [2:0] irq_level;
  logic [1:0] win_mode;
  logic [3:0] win_remain;

  always #5 clk = ~clk;

  dec_modifier_window dut_i (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .is_carry_mod(is_carry_mod),
    .is_level_mod(is_level_mod), .mod_imm(mod_imm), .flush(flush), .lvl_we(lvl_we),
    .lvl_wdata(lvl_wdata), .tag_cin(tag_cin), .tag_cout(tag_cout), .irq_level(irq_level),
    .win_mode(win_mode), .win_remain(win_remain));

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [10:0] exp_q[$];
  string req_q[$];

  int m_mode = 0, m_cnt = 0;
  logic [32:0] m_sh = '0;
  logic [2:0] m_base = '0;

  task automatic step(input logic v, cm, lm, input logic [32:0] imm, input logic fl, we,
                      input logic [2:0] wd, input string req);
    logic [10:0] e;
    @(negedge clk);
    inst_valid = v; is_carry_mod = cm; is_level_mod = lm; mod_imm = imm;
    flush = fl; lvl_we = we; lvl_wdata = wd;
    e[10] = (m_mode == 1) & m_sh[0];
    e[9]  = (m_mode == 1) & m_sh[1];
    e[8:6] = (m_mode == 2) ? m_sh[2:0] : m_base;
    e[5:4] = 2'(m_mode);
    e[3:0] = 4'(m_cnt);
    exp_q.push_back(e);
    req_q.push_back(req);
    if (we && m_mode != 2) m_base = wd;
    if (fl) begin m_mode = 0; m_cnt = 0; m_sh = '0; end
    else if (v && cm) begin m_mode = 1; m_cnt = 8; m_sh = {17'b0, imm[15:0]}; end
    else if (v && lm) begin m_mode = 2; m_cnt = 11; m_sh = imm; end
    else if (v && m_mode != 0) begin
      m_sh = (m_mode == 1) ? (m_sh >> 2) : (m_sh >> 3);
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) m_mode = 0;
    end
  endtask

  task automatic ins(input string req);  step(1, 0, 0, '0, 0, 0, 3'd0, req); endtask
  task automatic gap(input string req);  step(0, 0, 0, '0, 0, 0, 3'd0, req); endtask

  always begin
    @(negedge clk);
    #4;
    if (exp_q.size() != 0) begin
      logic [10:0] e, a;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = {tag_cin, tag_cout, irq_level, win_mode, win_remain};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got cin=%b cout=%b lvl=%0d mode=%0d rem=%0d, expected cin=%b cout=%b lvl=%0d mode=%0d rem=%0d",
                 r, a[10], a[9], a[8:6], a[5:4], a[3:0], e[10], e[9], e[8:6], e[5:4], e[3:0]);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [32:0] lv;
    gap("R1 reset");
    rst_n = 1'b1;
    gap("R1 idle after reset");
    step(0, 0, 0, '0, 0, 1, 3'd2, "R7 base write");
    gap("R6 base visible");
    // carry window with gaps: fields low first
    step(1, 0, 0, 33'h0_0000_E4B1, 0, 0, 3'd0, "R2 carry modifier");
    for (int i = 0; i < 8; i++) begin
      ins("R2 carry tag");
      if (i % 3 == 1) gap("R3 hold on gap");
    end
    gap("R4 carry window closed");
    ins("R4 no tag after window");
    // level window
    lv = '0;
    for (int i = 0; i < 11; i++) lv[3*i +: 3] = 3'(7 - (i % 8));
    step(1, 0, 1, lv, 0, 0, 3'd0, "R5 level modifier");
    ins("R5 level field");
    step(0, 0, 0, '0, 0, 1, 3'd5, "R7 write ignored in level window");
    for (int i = 0; i < 10; i++) begin
      ins("R5 level field");
      if (i == 4) gap("R3 hold on gap");
    end
    gap("R6 level restored");
    ins("R6 level restored after instr");
    // nested level modifier
    step(1, 0, 1, lv ^ 33'h1_2492_4924, 0, 0, 3'd0, "R8 level modifier");
    ins("R8 first field");
    ins("R8 second field");
    step(1, 0, 1, lv, 0, 0, 3'd0, "R8 replacing modifier");
    for (int i = 0; i < 11; i++) ins("R8 replaced window");
    gap("R8 original base restored");
    // carry replaced by carry
    step(1, 0, 0, 33'h0_0000_5555, 0, 0, 3'd0, "R8 carry");
    ins("R8 carry field");
    step(1, 0, 0, 33'h0_0000_AAAA, 0, 0, 3'd0, "R8 carry reload");
    for (int i = 0; i < 8; i++) ins("R8 carry reloaded");
    gap("R11 idle count zero");
    // flush mid level window
    step(1, 0, 1, lv, 0, 0, 3'd0, "R9 level modifier");
    ins("R9 field");
    step(0, 0, 0, '0, 1, 0, 3'd0, "R9 flush");
    gap("R9 after flush");
    step(1, 1, 0, 33'h0_0000_FFFF, 1, 0, 3'd0, "R9 flush beats modifier");
    gap("R9 modifier discarded");
    // both flags
    step(1, 1, 1, 33'h1_FFFF_0003, 0, 0, 3'd0, "R10 both flags");
    ins("R10 carry chosen");
    ins("R10 next");
    step(0, 0, 0, '0, 1, 1, 3'd6, "R7 write outside window");
    gap("R7 new base");
    gap("R11 final idle");
    @(negedge clk);
    #6;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule